// File: doc/BRIEF.md
# Receive Lane Polarity Inversion Detector

This block sits on a single receive lane between the 8b/10b decoder and the link training state machine. While link training is active it watches the training ordered sets arriving on the lane. If the identifier symbols of a complete set arrive bitwise complemented, the block concludes that the lane's differential pair is swapped. It then raises a sticky flag. From the next symbol on, it hands back a corrected symbol stream. The transmit direction is never touched.

Each lane carries its own instance. The decision is therefore made per lane, and some lanes of one link may end up inverted while others are not.

A symbol counter restarts on each comma (K28.5, byte 0xBC with the K flag set) and numbers the following valid symbols 1, 2, 3 and so on. The identifier window covers positions 6 to 15. The flag feeds the decoder, which applies the true correction at the 10-bit level. The byte-level complement on the output path models that correction for the balanced identifier codes.

Top module: `lane_polarity_detect`

## Requirements
- R1: After reset, `lane_inverted` and `cor_valid` are 0.
- R2: Every valid input symbol reappears on `cor_byte`/`cor_k` with `cor_valid` high exactly one clock later. `cor_k` always equals the input K flag.
- R3: While the flag is clear, `cor_byte` equals the input byte unchanged.
- R4: The flag sets when one ordered set, started by a comma and received while `train_active` is high, carries only inverted identifiers at positions 6 to 15. These are either all 0xB5 (inverted TS1) or all 0xBA (inverted TS2), as data characters. The flag changes on the clock that accepts position 15.
- R5: Sets with normal identifiers (0x4A, 0x45) never set the flag.
- R6: One non-inverted symbol anywhere in positions 6 to 15 prevents that set from setting the flag.
- R7: A set that mixes 0xB5 and 0xBA within its window does not set the flag.
- R8: Sets received while `train_active` is low do not set the flag.
- R9: Once set, the flag holds through any later traffic until reset or a `detect_entry` pulse. Either one clears it on the next clock.
- R10: While the flag is set, data characters leave complemented (`cor_byte` = ~input). K characters leave unchanged.
- R11: Symbols received before any comma, or more than 30 symbols after the last comma, are never compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_active | input | 1 | High while link training may decide polarity |
| detect_entry | input | 1 | Pulse on entry into detect; clears the flag and counter |
| rx_valid | input | 1 | Input symbol strobe |
| rx_k | input | 1 | Input symbol is a K character |
| rx_byte | input | 8 | Decoded input byte |
| cor_valid | output | 1 | Registered symbol strobe |
| cor_k | output | 1 | Registered K flag |
| cor_byte | output | 8 | Registered, polarity-corrected byte |
| lane_inverted | output | 1 | Sticky inversion decision, also the decoder's invert control |

## Verification
A counter that drifts from the true symbol position shows up on `lane_inverted` at the end of the first inverted set. The flag either stays low, or it rises on a set that had a defect in its window. A lost identifier kind or run state shows the same way on the mixed and flawed sets. A flag that is wrong at any moment appears on `cor_byte` one clock later, as data characters complemented or left alone against expectation. The scoreboard catches this on the very next valid symbol.

// File: rtl/lane_polarity_detect.sv
module lane_polarity_detect #(
  parameter int ID_FIRST = 6,
  parameter int ID_LAST  = 15,
  parameter int CW       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       train_active,
  input  logic       detect_entry,
  input  logic       rx_valid,
  input  logic       rx_k,
  input  logic [7:0] rx_byte,
  output logic       cor_valid,
  output logic       cor_k,
  output logic [7:0] cor_byte,
  output logic       lane_inverted
);
  localparam logic [7:0]    COMMA   = 8'hBC;
  localparam logic [7:0]    INV_TS1 = 8'hB5;
  localparam logic [7:0]    INV_TS2 = 8'hBA;
  localparam logic [CW-1:0] UNSYNC  = '1;
  localparam logic [CW-1:0] W_LO    = CW'(ID_FIRST);
  localparam logic [CW-1:0] W_HI    = CW'(ID_LAST);

  logic [CW-1:0] cnt;
  logic          run_ok;
  logic          kind;

  wire [CW-1:0] idx    = cnt + 1'b1;
  wire          is_com = rx_valid & rx_k & (rx_byte == COMMA);
  wire          in_win = rx_valid & ~is_com & (cnt != UNSYNC) & (idx >= W_LO) & (idx <= W_HI);
  wire          inv_id = ~rx_k & ((rx_byte == INV_TS1) | (rx_byte == INV_TS2));
  wire          same   = (idx == W_LO) | (rx_byte[0] == kind);
  wire          good   = inv_id & same;
  wire          hit    = in_win & run_ok & good & (idx == W_HI) & train_active;

  always_ff @(posedge clk) begin
    if (!rst_n || detect_entry) begin
      cnt           <= UNSYNC;
      run_ok        <= 1'b0;
      kind          <= 1'b0;
      lane_inverted <= 1'b0;
    end else if (rx_valid) begin
      if (is_com) begin
        cnt    <= '0;
        run_ok <= 1'b1;
      end else begin
        if (cnt != UNSYNC) cnt <= idx;
        if (in_win) begin
          run_ok <= run_ok & good;
          if (idx == W_LO) kind <= rx_byte[0];
        end
      end
      if (hit) lane_inverted <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cor_valid <= 1'b0;
      cor_k     <= 1'b0;
      cor_byte  <= '0;
    end else begin
      cor_valid <= rx_valid;
      cor_k     <= rx_k;
      cor_byte  <= (lane_inverted & ~rx_k) ? ~rx_byte : rx_byte;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> cor_valid);
  a_r2_k_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cor_valid |-> cor_k == $past(rx_k));
  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_valid && !$past(lane_inverted)) |-> cor_byte == $past(rx_byte));
  a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_valid && !cor_k && $past(lane_inverted)) |-> cor_byte == ~$past(rx_byte));
  a_r8_only_training: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_inverted) |-> $past(train_active && rx_valid));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_inverted && !detect_entry) |=> lane_inverted);
  a_r9_detect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    detect_entry |=> !lane_inverted);
endmodule

// File: tb/sim_lane_polarity_detect.sv
module sim_lane_polarity_detect;
  logic clk = 1'b0, rst_n = 1'b0, train_active = 1'b0, detect_entry = 1'b0;
  logic rx_valid = 1'b0, rx_k = 1'b0;
  logic [7:0] rx_byte = '0;
  logic cor_valid, cor_k, lane_inverted;
  logic [7:0] cor_byte;

  int checks = 0, fails = 0;
  logic [9:0] sbq[$];
  bit mflag = 0, mok = 0, mkind = 0;
  int mcnt = -1;

  always #5 clk = ~clk;

  lane_polarity_detect u0 (.clk, .rst_n, .train_active, .detect_entry, .rx_valid,
    .rx_k, .rx_byte, .cor_valid, .cor_k, .cor_byte, .lane_inverted);

  always @(negedge clk) begin
    if (rst_n && cor_valid) begin
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL R2: output symbol %h with nothing expected, expected none", cor_byte);
      end else begin
        logic [9:0] e;
        e = sbq.pop_front();
        if ({cor_k, cor_byte} != e[8:0]) begin
          fails++;
          $display("FAIL %s: got k=%0b byte=%h, expected k=%0b byte=%h",
                   e[9] ? "R10" : "R3", cor_k, cor_byte, e[8], e[7:0]);
        end
      end
    end
  end

  task automatic send_sym(input bit k, input logic [7:0] b);
    bit g, h;
    sbq.push_back({mflag, k, (mflag && !k) ? ~b : b});
    if (k && b == 8'hBC) begin
      mcnt = 0; mok = 1;
    end else if (mcnt >= 0) begin
      mcnt = (mcnt >= 30) ? -1 : mcnt + 1;
      if (mcnt >= 6 && mcnt <= 15) begin
        g = !k && (b == 8'hB5 || b == 8'hBA) && (mcnt == 6 || b[0] == mkind);
        h = mok && g && mcnt == 15 && train_active;
        if (mcnt == 6) mkind = b[0];
        mok = mok && g;
        if (h) mflag = 1;
      end
    end
    rx_valid = 1; rx_k = k; rx_byte = b;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    rx_valid = 0; rx_k = 0; rx_byte = 0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_ts(input logic [7:0] lo_id, input logic [7:0] hi_id,
                         input int bad_pos, input logic [7:0] bad_val);
    send_sym(1, 8'hBC);
    for (int i = 1; i < 16; i++) begin
      logic [7:0] v;
      if (i < 6) v = 8'h10 + 8'(i);
      else v = (i <= 10) ? lo_id : hi_id;
      if (i == bad_pos) v = bad_val;
      send_sym(0, v);
    end
  endtask

  task automatic chk_flag(input string req, input bit exp);
    checks++;
    if (lane_inverted !== exp) begin
      fails++;
      $display("FAIL %s: lane_inverted=%0b, expected %0b", req, lane_inverted, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    checks++;
    if (lane_inverted !== 0 || cor_valid !== 0) begin
      fails++;
      $display("FAIL R1: flag=%0b valid=%0b, expected 0 0", lane_inverted, cor_valid);
    end
    rst_n = 1; train_active = 1;
    idle(1);
    // R11: inverted identifiers with no comma seen
    for (int i = 0; i < 20; i++) send_sym(0, 8'hB5);
    idle(2); chk_flag("R11", 0);
    // R11: comma, then 30 fillers, then inverted identifiers beyond the counter range
    send_sym(1, 8'hBC);
    for (int i = 0; i < 30; i++) send_sym(0, 8'h00);
    for (int i = 0; i < 10; i++) send_sym(0, 8'hB5);
    idle(2); chk_flag("R11", 0);
    // R5: normal TS1 and TS2 sets
    send_ts(8'h4A, 8'h4A, 0, 0); send_ts(8'h45, 8'h45, 0, 0);
    idle(2); chk_flag("R5", 0);
    // R6: one flaw in the window
    send_ts(8'hB5, 8'hB5, 10, 8'h4A); idle(2); chk_flag("R6", 0);
    send_ts(8'hBA, 8'hBA, 15, 8'h45); idle(2); chk_flag("R6", 0);
    // R7: mixed identifiers
    send_ts(8'hB5, 8'hBA, 0, 0); idle(2); chk_flag("R7", 0);
    // R8: training inactive
    train_active = 0;
    send_ts(8'hB5, 8'hB5, 0, 0); idle(2); chk_flag("R8", 0);
    train_active = 1;
    // R4: inverted TS1 set
    send_ts(8'hB5, 8'hB5, 0, 0); idle(2); chk_flag("R4", 1);
    // R10: data complemented, K chars unchanged
    send_sym(0, 8'h3C); send_sym(1, 8'h1C); send_sym(0, 8'hF0); send_sym(1, 8'hBC);
    // R9: normal sets and training off do not clear the flag
    send_ts(8'h4A, 8'h4A, 0, 0); train_active = 0;
    send_sym(0, 8'h55); idle(2); chk_flag("R9", 1);
    train_active = 1;
    detect_entry = 1; @(posedge clk); #1; detect_entry = 0;
    mflag = 0; mcnt = -1; mok = 0;
    idle(1); chk_flag("R9", 0);
    // R4: inverted TS2 set
    send_ts(8'hBA, 8'hBA, 0, 0); idle(2); chk_flag("R4", 1);
    send_sym(0, 8'h00); idle(2);
    rst_n = 0; idle(2); chk_flag("R1", 0);
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d symbols never emitted, expected 0", sbq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule